// File: doc/BRIEF.md
# Dual-Core Level Interrupt Router

This block gathers level-sensitive, active-high interrupt requests from on-board peripherals and fans them out to four outputs. Two outputs are ordinary interrupt lines, one per processor core. The other two are machine-check lines, again one per core. Every request passes through a two-stage synchronizer, and the synchronized levels form a raw status word. Four independent enable masks each select which requests reach one output. An output is high whenever at least one enabled request is high. There is no acknowledge: a line falls only when its source falls or software clears the enable bit.

Software reaches the block through a synchronous single-cycle register port. A write lands on the clock edge that samples it. A read returns its data on `bus_rdata_o` in the cycle after the request, and the port presents zero when no read is pending. Each sampled bus cycle falls into one of three access kinds, ACC_IDLE, ACC_READ and ACC_WRITE, chosen from `bus_sel_i` and `bus_wr_i` every clock. There are no multi-cycle transitions between them: each cycle is classified on its own. The register offsets are byte addresses:

- 0x00: raw status, read-only.
- 0x10 and 0x14: normal-interrupt enables for core 0 and core 1.
- 0x18 and 0x1C: machine-check enables for core 0 and core 1.

Top module: `lvl_irq_router`

## Requirements
- R1: Reading offset 0x00 returns the synchronized level of request n in bit n for n = 0..16. Bits 17..31 read as zero. A change on a request pin appears in the status word two clocks after it is sampled.
- R2: The enable registers at 0x10 (interrupt, core 0), 0x14 (interrupt, core 1), 0x18 (machine check, core 0) and 0x1C (machine check, core 1) are 32-bit read/write. They read back exactly what was last written, and they change only on a write to their own offset.
- R3: Each output is registered. It equals the OR over all bits of (status AND its enable mask), one clock after that status or mask value exists. The outputs are `irq_core_o[0]` (mask 0x10), `irq_core_o[1]` (0x14), `mchk_core_o[0]` (0x18) and `mchk_core_o[1]` (0x1C).
- R4: A request enabled in several masks drives all of the selected outputs in the same cycle, with no arbitration between them.
- R5: No acknowledge exists. An asserted output stays high for as long as its source is high and its enable bit is set. It falls only after the source falls or the bit is cleared.
- R6: After reset all four masks are zero, all outputs are low and `bus_rdata_o` is zero.
- R7: A write to any offset other than the four enable registers changes no state. A read of any offset other than the five mapped ones returns zero.
- R8: A write to offset 0x00 has no effect on the status word.
- R9: Read data appears on `bus_rdata_o` exactly one clock after the read request, and `bus_rdata_o` is zero in any cycle that follows a non-read cycle.
- R10: Request inputs 17..31 never affect any output, even when their enable bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 32 | Level-sensitive interrupt requests, active high, asynchronous |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_core_o | output | 2 | Normal interrupt line per core |
| mchk_core_o | output | 2 | Machine-check line per core |

## Verification
The routing is first tried with one request enabled in a single mask, which shows that each mask reaches only its own line. The same request is then enabled in all four masks, which separates independent fan-out from any arbitration. A request held for many cycles, then dropped, then masked off, shows that nothing clears a line except the level or the enable. Patterns that drive only the unwired upper inputs against all-ones masks, and an exact cycle-count sample around a request edge, separate correct width handling and a three-register latency from off-by-one pipelines. Writes and reads at reserved and status offsets, followed by mask read-back, show that stray accesses alter nothing.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int unsigned LINE_COUNT = 4;

    // Line order: irq core0, irq core1, mchk core0, mchk core1
    localparam int unsigned LINE_IRQ0  = 0;
    localparam int unsigned LINE_IRQ1  = 1;
    localparam int unsigned LINE_MCHK0 = 2;
    localparam int unsigned LINE_MCHK1 = 3;

    localparam logic [7:0] OFS_RAW  = 8'h00;
    localparam logic [7:0] OFS_IEN0 = 8'h10;
    localparam logic [7:0] OFS_IEN1 = 8'h14;
    localparam logic [7:0] OFS_MCE0 = 8'h18;
    localparam logic [7:0] OFS_MCE1 = 8'h1C;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        REG_NONE = 3'd0,
        REG_RAW  = 3'd1,
        REG_IEN0 = 3'd2,
        REG_IEN1 = 3'd3,
        REG_MCE0 = 3'd4,
        REG_MCE1 = 3'd5
    } reg_e;

    function automatic reg_e decode_ofs(input logic [7:0] ofs);
        reg_e r;
        unique case (ofs)
            OFS_RAW:  r = REG_RAW;
            OFS_IEN0: r = REG_IEN0;
            OFS_IEN1: r = REG_IEN1;
            OFS_MCE0: r = REG_MCE0;
            OFS_MCE1: r = REG_MCE1;
            default:  r = REG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned WIRED  = 17,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    localparam int unsigned SPARE = WIDTH - WIRED;

    for (genvar b = 0; b < WIRED; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign level_o[b] = chain_q[STAGES-1];
    end

    if (SPARE > 0) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^async_i[WIDTH-1:WIRED];
        assign level_o[WIDTH-1:WIRED] = '0;
    end

endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             sel_i,
    input  logic                             wr_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [WIDTH-1:0]                 wdata_i,
    input  logic [WIDTH-1:0]                 status_i,
    output logic [LINE_COUNT-1:0][WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0]                 rdata_o
);

    acc_e                             acc;
    reg_e                             target;
    logic [LINE_COUNT-1:0][WIDTH-1:0] mask_q;
    logic [WIDTH-1:0]                 rd_mux;
    logic [WIDTH-1:0]                 rdata_q;

    always_comb begin
        unique case ({sel_i, wr_i})
            2'b10:   acc = ACC_READ;
            2'b11:   acc = ACC_WRITE;
            default: acc = ACC_IDLE;
        endcase
    end

    assign target = decode_ofs(8'(addr_i));

    // Enable masks: only an exact-offset write updates one of them
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (acc == ACC_WRITE) begin
            unique case (target)
                REG_IEN0: mask_q[LINE_IRQ0]  <= wdata_i;
                REG_IEN1: mask_q[LINE_IRQ1]  <= wdata_i;
                REG_MCE0: mask_q[LINE_MCHK0] <= wdata_i;
                REG_MCE1: mask_q[LINE_MCHK1] <= wdata_i;
                default:  mask_q <= mask_q;
            endcase
        end
    end

    always_comb begin
        unique case (target)
            REG_RAW:  rd_mux = status_i;
            REG_IEN0: rd_mux = mask_q[LINE_IRQ0];
            REG_IEN1: rd_mux = mask_q[LINE_IRQ1];
            REG_MCE0: rd_mux = mask_q[LINE_MCHK0];
            REG_MCE1: rd_mux = mask_q[LINE_MCHK1];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else begin
            unique case (acc)
                ACC_READ: rdata_q <= rd_mux;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/lvl_irq_reduce.sv
module lvl_irq_reduce #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] enable_i,
    output logic             line_o
);

    logic line_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            line_q <= 1'b0;
        end else begin
            line_q <= |(status_i & enable_i);
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned WIRED_SRC   = 17,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic [1:0]         irq_core_o,
    output logic [1:0]         mchk_core_o
);

    logic [NUM_SRC-1:0]                 status_w;
    logic [LINE_COUNT-1:0][NUM_SRC-1:0] mask_w;
    logic [LINE_COUNT-1:0]              line_w;

    lvl_irq_sync #(
        .WIDTH  (NUM_SRC),
        .WIRED  (WIRED_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_req_i),
        .level_o (status_w)
    );

    lvl_irq_regs #(
        .WIDTH  (NUM_SRC),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status_w),
        .mask_o   (mask_w),
        .rdata_o  (bus_rdata_o)
    );

    for (genvar k = 0; k < LINE_COUNT; k++) begin : g_line
        lvl_irq_reduce #(
            .WIDTH (NUM_SRC)
        ) u_reduce (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .status_i (status_w),
            .enable_i (mask_w[k]),
            .line_o   (line_w[k])
        );
    end

    assign irq_core_o  = {line_w[LINE_IRQ1],  line_w[LINE_IRQ0]};
    assign mchk_core_o = {line_w[LINE_MCHK1], line_w[LINE_MCHK0]};

endmodule

// File: rtl/lvl_irq_router_chk.sv
module lvl_irq_router_chk
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned WIRED_SRC   = 17,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 8
) (
    input logic                               clk_i,
    input logic                               rst_ni,
    input logic [NUM_SRC-1:0]                 irq_req_i,
    input logic                               bus_sel_i,
    input logic                               bus_wr_i,
    input logic [ADDR_W-1:0]                  bus_addr_i,
    input logic [NUM_SRC-1:0]                 bus_rdata_o,
    input logic [1:0]                         irq_core_o,
    input logic [1:0]                         mchk_core_o,
    input logic [NUM_SRC-1:0]                 status_w,
    input logic [LINE_COUNT-1:0][NUM_SRC-1:0] mask_w
);

    logic [1:0] cyc_q;
    logic [3:0] lines;
    logic       rd_req;
    logic       wr_req;
    logic       mapped;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    assign lines  = {mchk_core_o, irq_core_o};
    assign rd_req = bus_sel_i && !bus_wr_i;
    assign wr_req = bus_sel_i && bus_wr_i;
    assign mapped = (decode_ofs(8'(bus_addr_i)) != REG_NONE);

    // R6: quiet outputs on the first cycle after reset
    p_reset_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q == 2'd0) |-> (lines == 4'b0 && bus_rdata_o == '0));

    // R3: each line follows its masked status one cycle later
    for (genvar k = 0; k < LINE_COUNT; k++) begin : g_line_chk
        p_line_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cyc_q != 2'd0) |-> (lines[k] == $past(|(status_w & mask_w[k]))));
    end

    // R1: status lags the request pins by the synchronizer depth
    if (SYNC_STAGES == 2) begin : g_lag_chk
        p_sync_lag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cyc_q >= 2'd2) |->
            (status_w[WIRED_SRC-1:0] == $past(irq_req_i[WIRED_SRC-1:0], 2)));
    end

    // R1: upper status bits read zero
    p_raw_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && bus_addr_i == ADDR_W'(OFS_RAW)) |=>
        (bus_rdata_o[NUM_SRC-1:WIRED_SRC] == '0));

    // R9: read port idles at zero
    p_rdata_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_req |=> (bus_rdata_o == '0));

    // R7: unmapped reads return zero
    p_unmapped_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && !mapped) |=> (bus_rdata_o == '0));

    // R2: masks hold without a write
    p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_req |=> $stable(mask_w));

endmodule

bind lvl_irq_router lvl_irq_router_chk #(
    .NUM_SRC     (NUM_SRC),
    .WIRED_SRC   (WIRED_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_req_i   (irq_req_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_core_o  (irq_core_o),
    .mchk_core_o (mchk_core_o),
    .status_w    (status_w),
    .mask_w      (mask_w)
);

// File: tb/lvl_irq_router_bench.sv
module lvl_irq_router_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] irq_req_i = '0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [1:0]  irq_core_o;
    logic [1:0]  mchk_core_o;

    int checks = 0;
    int errors = 0;
    logic  [31:0] exp_q[$];
    string        tag_q[$];
    logic         issued = 1'b0;

    always #5 clk_i = ~clk_i;

    lvl_irq_router u_lvl_irq_router (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .irq_req_i   (irq_req_i),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_core_o  (irq_core_o),
        .mchk_core_o (mchk_core_o)
    );

    // Monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk_i) issued <= bus_sel_i && !bus_wr_i && rst_ni;

    always @(negedge clk_i) begin
        if (issued && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata_o !== e) begin
                errors++;
                $display("FAIL %s rdata=%h expected=%h", t, bus_rdata_o, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_i);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk_i);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk_i);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk_i);
        bus_sel_i = 1'b0;
    endtask

    task automatic set_req(input logic [31:0] v);
        @(negedge clk_i);
        irq_req_i = v;
    endtask

    task automatic chk_out(input logic [1:0] ei, input logic [1:0] em, input string t);
        checks++;
        if (irq_core_o !== ei || mchk_core_o !== em) begin
            errors++;
            $display("FAIL %s irq=%b mchk=%b expected irq=%b mchk=%b",
                     t, irq_core_o, mchk_core_o, ei, em);
        end
    endtask

    task automatic chk_idle(input string t);
        checks++;
        if (bus_rdata_o !== 32'h0) begin
            errors++;
            $display("FAIL %s idle rdata=%h expected=00000000", t, bus_rdata_o);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        chk_out(2'b00, 2'b00, "R6 outputs in reset");
        chk_idle("R6 rdata in reset");
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk_out(2'b00, 2'b00, "R6 outputs after reset");
        bus_read(8'h10, 32'h0, "R6 ien0 reset");
        bus_read(8'h14, 32'h0, "R6 ien1 reset");
        bus_read(8'h18, 32'h0, "R6 mce0 reset");
        bus_read(8'h1C, 32'h0, "R6 mce1 reset");
        @(negedge clk_i);
        chk_idle("R9 rdata zero between reads");

        // R2: distinct full-width patterns, read back
        bus_write(8'h10, 32'hA5A5_0F0F);
        bus_write(8'h14, 32'h5A5A_F0F0);
        bus_write(8'h18, 32'hFFFF_0001);
        bus_write(8'h1C, 32'h8000_0000);
        bus_read(8'h10, 32'hA5A5_0F0F, "R2 ien0 readback");
        bus_read(8'h14, 32'h5A5A_F0F0, "R2 ien1 readback");
        bus_read(8'h18, 32'hFFFF_0001, "R2 mce0 readback");
        bus_read(8'h1C, 32'h8000_0000, "R2 mce1 readback");

        // R3: single path, exact latency
        bus_write(8'h10, 32'h0000_0020);
        bus_write(8'h14, 32'h0);
        bus_write(8'h18, 32'h0);
        bus_write(8'h1C, 32'h0);
        set_req(32'h0000_0020);
        @(negedge clk_i);
        @(negedge clk_i);
        chk_out(2'b00, 2'b00, "R3 not yet at two clocks");
        @(negedge clk_i);
        chk_out(2'b01, 2'b00, "R3 asserted at three clocks");
        bus_read(8'h00, 32'h0000_0020, "R1 status single bit");

        // R4: same request enabled on all four paths
        bus_write(8'h14, 32'h0000_0020);
        bus_write(8'h18, 32'h0000_0020);
        bus_write(8'h1C, 32'h0000_0020);
        @(negedge clk_i);
        chk_out(2'b11, 2'b11, "R4 all four lines together");

        // R5: no acknowledge; hold, drop, re-raise, unmask
        repeat (10) @(negedge clk_i);
        chk_out(2'b11, 2'b11, "R5 held while level high");
        set_req(32'h0);
        repeat (3) @(negedge clk_i);
        chk_out(2'b00, 2'b00, "R5 drops with source");
        set_req(32'h0000_0020);
        repeat (3) @(negedge clk_i);
        chk_out(2'b11, 2'b11, "R5 reasserts with source");
        bus_write(8'h10, 32'h0);
        @(negedge clk_i);
        chk_out(2'b10, 2'b11, "R5 drops on mask clear");

        // R10: only unwired inputs, all masks open
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        set_req(32'hFFFE_0000);
        repeat (4) @(negedge clk_i);
        chk_out(2'b00, 2'b00, "R10 upper inputs ignored");
        bus_read(8'h00, 32'h0, "R10 upper inputs read zero");

        // R1: mixed pattern, upper bits masked from status
        set_req(32'hABCD_1234);
        repeat (3) @(negedge clk_i);
        chk_out(2'b11, 2'b11, "R3 mixed pattern all masks open");
        bus_read(8'h00, 32'h0001_1234, "R1 status mixed pattern");

        // R7: stray writes and unmapped reads
        bus_write(8'h04, 32'h0);
        bus_write(8'h20, 32'h0);
        bus_write(8'h11, 32'h0);
        bus_read(8'h10, 32'hFFFF_FFFF, "R7 ien0 untouched");
        bus_read(8'h1C, 32'hFFFF_FFFF, "R7 mce1 untouched");
        bus_read(8'h04, 32'h0, "R7 unmapped read 0x04");
        bus_read(8'h0C, 32'h0, "R7 unmapped read 0x0C");
        bus_read(8'h11, 32'h0, "R7 unmapped read 0x11");
        chk_out(2'b11, 2'b11, "R7 outputs unaffected");

        // R8: write to the status offset
        bus_write(8'h00, 32'h0000_0000);
        bus_read(8'h00, 32'h0001_1234, "R8 status unchanged after write");
        @(negedge clk_i);
        chk_idle("R9 rdata returns to zero");

        repeat (3) @(negedge clk_i);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule